// File: doc/BRIEF.md
# Single-Channel DMA Beat Engine

This block is one DMA channel. A start pulse latches a source address, a destination address, a beat count and a small set of control settings. The channel then moves that many halfword or word beats. Each beat reads one item from the source and writes it to the destination over a simple memory bus that the channel masters. The address step for each side is fixed when the transfer starts and is added after every beat. Each side can walk upward, walk downward or stay put. A FIFO setting overrides the count and the width so that one start moves exactly four 32-bit words. A completion interrupt may be raised after the last beat.

The bus side is valid/ready. The engine raises `bus_valid` with a stable request and holds the request until the cycle in which `bus_ready` is high. A read completes in that cycle, and `bus_rdata` must be valid in the same cycle. The memory can stall any access for as many cycles as it needs. The engine has no other back-pressure. `start` is a plain level that the engine samples only while it is idle.

Top module: `dma_xfer_engine`

## Requirements
- R1: With `cfg_wide`=1, beats are 4 bytes and `bus_word`=1. With `cfg_wide`=0, beats are 2 bytes and `bus_word`=0, and the written data is the low 16 bits of the read data with the upper 16 bits zero.
- R2: Source mode 0 adds the beat size to the source address after each beat. Mode 1 subtracts the beat size. Mode 2 keeps the address unchanged.
- R3: Source mode 3 is illegal. The source address stays fixed for that transfer, and `src_err` goes high at the start and stays high until reset.
- R4: Destination modes 0, 1 and 2 step the destination address by +size, −size and 0. Destination mode 3 also steps by +size.
- R5: The steps, the width, the FIFO setting, the count and the interrupt enable are captured at start. Changing the config inputs during a transfer has no effect on it.
- R6: On the bus, a word address has bits [1:0] cleared and a halfword address has bit 0 cleared. The internal address is not masked.
- R7: Both the read and the write of the first beat have `bus_seq`=0. Every later access of the same transfer has `bus_seq`=1.
- R8: With `cfg_fifo`=1, exactly four word beats (4-byte step, `bus_word`=1) are moved, whatever `cfg_count` and `cfg_wide` hold.
- R9: A `cfg_count` of 0 moves 2**CNT_W beats.
- R10: Each beat is a read of the source (`bus_we`=0) followed by a write (`bus_we`=1) to the destination. The write data comes from the data taken at the read handshake.
- R11: While `bus_valid`=1 and `bus_ready`=0, the request (`bus_valid`, `bus_we`, `bus_addr`) stays unchanged in the next cycle.
- R12: `busy` rises in the cycle after an accepted start. It stays high through the cycle after the last write handshake. In that cycle, `irq` pulses for one cycle if interrupts were enabled. `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| cfg_wide | input | 1 | 1 = word beats, 0 = halfword beats |
| cfg_src_mode | input | 2 | Source mode: 0 inc, 1 dec, 2 fixed, 3 illegal |
| cfg_dst_mode | input | 2 | Destination mode: 0 inc, 1 dec, 2 fixed, 3 inc |
| cfg_fifo | input | 1 | Force four word beats |
| cfg_irq_en | input | 1 | Pulse irq on completion |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_count | input | CNT_W | Beat count, 0 = 2**CNT_W |
| bus_valid | output | 1 | Access request |
| bus_ready | input | 1 | Access accepted / read data valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| bus_seq | output | 1 | 1 = sequential access |
| bus_addr | output | ADDR_W | Aligned access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion pulse |
| src_err | output | 1 | Sticky illegal-source-mode flag |

## Verification
The bench targets several failure points:
- Decrement modes combined with odd start addresses. If the step or the alignment mask is wrong, the address stream drifts from the first beat onward.
- A FIFO run with a nonzero halfword count. A design that honoured the count or the width would produce extra beats or halfword accesses.
- A zero count. This catches a channel that moves nothing instead of the maximum.
- Stalls from `bus_ready` in a regular pattern. These expose requests that change while waiting, and read data captured on the wrong cycle.
- A second start with different settings in the middle of a transfer. A design that re-latched the configuration would change its steps or its count part-way through.
- The illegal source mode. This checks that the address freezes and that the error flag stays set.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2,
    AM_ALT = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit IS_DST = 1'b0
) (
  input  logic [1:0]        mode,
  input  logic              wide,
  output logic [ADDR_W-1:0] step,
  output logic              illegal
);
  logic [ADDR_W-1:0] size;

  always_comb begin
    size    = wide ? ADDR_W'(4) : ADDR_W'(2);
    illegal = 1'b0;
    unique case (addr_mode_e'(mode))
      AM_INC: step = size;
      AM_DEC: step = '0 - size;
      AM_FIX: step = '0;
      default: begin
        // code 3: increment for the destination, frozen + flagged for source
        if (IS_DST) begin
          step = size;
        end else begin
          step    = '0;
          illegal = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step_in,
  input  logic              advance,
  input  logic              wide,
  output logic [ADDR_W-1:0] bus_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (load) begin
      addr_q <= base;
      step_q <= step_in;
    end else if (advance) begin
      addr_q <= addr_q + step_q;
    end
  end

  assign bus_addr = wide ? {addr_q[ADDR_W-1:2], 2'b00}
                         : {addr_q[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
  import dma_xfer_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_fifo,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_irq_en,
  input  logic             bus_ready,
  output xfer_state_e      state,
  output logic             launch,
  output logic             seq,
  output logic             busy,
  output logic             irq
);
  localparam logic [CNT_W:0] MAX_BEATS  = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] FIFO_BEATS = (CNT_W+1)'(4);

  xfer_state_e    state_q;
  logic [CNT_W:0] left_q;
  logic           seq_q;
  logic           irq_en_q;

  assign launch = start && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      seq_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q  <= ST_READ;
          seq_q    <= 1'b0;
          irq_en_q <= cfg_irq_en;
          if (cfg_fifo)             left_q <= FIFO_BEATS;
          else if (cfg_count == '0) left_q <= MAX_BEATS;
          else                      left_q <= {1'b0, cfg_count};
        end
        ST_READ: if (bus_ready) state_q <= ST_WRITE;
        ST_WRITE: if (bus_ready) begin
          seq_q  <= 1'b1;
          left_q <= left_q - 1'b1;
          state_q <= (left_q == (CNT_W+1)'(1)) ? ST_DONE : ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state = state_q;
  assign seq   = seq_q;
  assign busy  = (state_q != ST_IDLE);
  assign irq   = (state_q == ST_DONE) && irq_en_q;

  // R12
  irq_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);

  // R7
  first_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !seq);

  // R12
  done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_src_mode,
  input  logic [1:0]        cfg_dst_mode,
  input  logic              cfg_fifo,
  input  logic              cfg_irq_en,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic              bus_word,
  output logic              bus_seq,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              busy,
  output logic              irq,
  output logic              src_err
);
  xfer_state_e       state;
  logic              launch;
  logic              seq;
  logic              eff_wide;
  logic              wide_q;
  logic              fifo_q;
  logic              err_q;
  logic [WORD_W-1:0] data_q;
  logic              advance;
  logic [ADDR_W-1:0] src_step, dst_step;
  logic              src_bad, dst_bad;
  logic [ADDR_W-1:0] src_bus, dst_bus;

  assign eff_wide = cfg_fifo | cfg_wide;

  dma_step_calc #(.ADDR_W(ADDR_W), .IS_DST(1'b0)) u_src_step (
    .mode(cfg_src_mode), .wide(eff_wide), .step(src_step), .illegal(src_bad));

  dma_step_calc #(.ADDR_W(ADDR_W), .IS_DST(1'b1)) u_dst_step (
    .mode(cfg_dst_mode), .wide(eff_wide), .step(dst_step), .illegal(dst_bad));

  dma_beat_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_fifo(cfg_fifo),
    .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en), .bus_ready(bus_ready),
    .state(state), .launch(launch), .seq(seq), .busy(busy), .irq(irq));

  assign advance = (state == ST_WRITE) && bus_ready;

  dma_addr_track #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(cfg_src_addr),
    .step_in(src_step), .advance(advance), .wide(wide_q), .bus_addr(src_bus));

  dma_addr_track #(.ADDR_W(ADDR_W)) u_dst_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .base(cfg_dst_addr),
    .step_in(dst_step), .advance(advance), .wide(wide_q), .bus_addr(dst_bus));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      fifo_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (launch) begin
        wide_q <= eff_wide;
        fifo_q <= cfg_fifo;
        if (src_bad) err_q <= 1'b1;
      end
      if ((state == ST_READ) && bus_ready)
        data_q <= wide_q ? bus_rdata : {16'h0000, bus_rdata[15:0]};
    end
  end

  assign bus_valid = (state == ST_READ) || (state == ST_WRITE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_word  = wide_q;
  assign bus_seq   = seq;
  assign bus_addr  = bus_we ? dst_bus : src_bus;
  assign bus_wdata = data_q;
  assign src_err   = err_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> src_err);

  // R8
  fifo_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && fifo_q) |-> bus_word);

  // R10
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_ready) |=> (bus_valid && bus_we));
endmodule

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  localparam int AW = 32;
  localparam int CW = 6;

  typedef struct packed {
    logic        we;
    logic        seq;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cfg_wide = 1'b0, cfg_fifo = 1'b0, cfg_irq_en = 1'b0;
  logic [1:0] cfg_src_mode = 2'd0, cfg_dst_mode = 2'd0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic bus_valid, bus_ready = 1'b0, bus_we, bus_word, bus_seq;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic busy, irq, src_err;

  int checks = 0, errors = 0, cyc_total = 0;
  bit err_expected = 1'b0;
  acc_t q[$];

  always #4 clk = ~clk;

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[31:16] + a[15:0] + 16'h1234};
  endfunction

  assign bus_rdata = memf(bus_addr);

  dma_xfer_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dma_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wide(cfg_wide),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .cfg_fifo(cfg_fifo), .cfg_irq_en(cfg_irq_en),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_count(cfg_count), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_word(bus_word), .bus_seq(bus_seq),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .irq(irq), .src_err(src_err));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(bit wide, logic [1:0] sm, logic [1:0] dm, bit fifo,
                     bit irqen, logic [31:0] sa0, logic [31:0] da0,
                     int cnt, bit stall, bit disturb);
    int n, sz;
    logic [31:0] ss, ds, sa, da, rd;
    bit started;
    n  = fifo ? 4 : (cnt == 0 ? (1 << CW) : cnt);
    sz = (fifo || wide) ? 4 : 2;
    ss = (sm == 2'd0) ? sz : (sm == 2'd1) ? -sz : 0;
    ds = (dm == 2'd1) ? -sz : (dm == 2'd2) ? 0 : sz;
    if (sm == 2'd3) err_expected = 1'b1;
    q.delete();
    for (int i = 0; i < n; i++) begin
      sa = sa0 + i * ss;
      da = da0 + i * ds;
      sa = (sz == 4) ? {sa[31:2], 2'b00} : {sa[31:1], 1'b0};
      da = (sz == 4) ? {da[31:2], 2'b00} : {da[31:1], 1'b0};
      rd = memf(sa);
      q.push_back('{we: 1'b0, seq: (i > 0), addr: sa, data: 32'h0});
      q.push_back('{we: 1'b1, seq: (i > 0), addr: da,
                    data: (sz == 4) ? rd : {16'h0, rd[15:0]}});
    end
    cfg_wide = wide; cfg_src_mode = sm; cfg_dst_mode = dm; cfg_fifo = fifo;
    cfg_irq_en = irqen; cfg_src_addr = sa0; cfg_dst_addr = da0;
    cfg_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    started = 1'b1;
    for (int it = 0; it < 3000 && q.size() > 0; it++) begin
      chk("R12 busy during transfer", busy, 1);
      chk("R11 valid held", bus_valid, 1);
      chk("R10 read/write order", bus_we, q[0].we);
      chk("R2/R4/R6 address", bus_addr, q[0].addr);
      chk("R7 seq flag", bus_seq, q[0].seq);
      chk("R1/R8 access width", bus_word, (sz == 4));
      if (q[0].we) chk("R1/R10 write data", bus_wdata, q[0].data);
      if (disturb && it == 3) begin
        // R5 / R12: new start and new config mid-transfer must be ignored
        start = 1'b1; cfg_src_mode = 2'd2; cfg_dst_mode = 2'd1;
        cfg_wide = ~wide; cfg_count = CW'(1); cfg_irq_en = ~irqen;
        cfg_src_addr = 32'h0BAD_0000; cfg_fifo = 1'b1;
      end
      if (disturb && it == 4) start = 1'b0;
      bus_ready = !stall || (it % 3 != 1);
      if (bus_ready) void'(q.pop_front());
      @(negedge clk);
    end
    bus_ready = 1'b0;
    chk("R12 irq on done", irq, irqen);
    chk("R12 busy on done", busy, 1);
    chk("R12 no access on done", bus_valid, 0);
    @(negedge clk);
    chk("R12 idle after done", busy, 0);
    chk("R12 irq one pulse", irq, 0);
    chk("R3 error flag", src_err, err_expected);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset irq", irq, 0);
    chk("R11 reset valid", bus_valid, 0);
    chk("R3 reset error", src_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R4: word inc/inc
    run(1, 2'd0, 2'd0, 0, 1, 32'h0000_1000, 32'h0000_8000, 5, 0, 0);
    // R1 R6 R11: halfword dec/dec, odd addresses, stalls
    run(0, 2'd1, 2'd1, 0, 1, 32'h0000_2003, 32'h0000_9005, 4, 1, 0);
    // R4 R6: fixed source, dst mode 3, word, misaligned
    run(1, 2'd2, 2'd3, 0, 1, 32'h0000_3006, 32'h0000_A001, 3, 1, 0);
    // R2 R4: halfword inc source, fixed destination
    run(0, 2'd0, 2'd2, 0, 0, 32'h0000_4001, 32'h0000_B002, 6, 0, 0);
    // R8: FIFO overrides count and width
    run(0, 2'd0, 2'd2, 1, 1, 32'h0000_5002, 32'h0000_C000, 9, 1, 0);
    // R5 R12: disturbed transfer, irq disabled
    run(0, 2'd0, 2'd0, 0, 0, 32'h0000_6000, 32'h0000_D000, 5, 1, 1);
    // R3: illegal source mode
    run(0, 2'd3, 2'd0, 0, 1, 32'h0000_7001, 32'h0000_E000, 4, 0, 0);
    // R9: zero count means maximum
    run(0, 2'd0, 2'd1, 0, 1, 32'h0001_0000, 32'h0002_0000, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule